// File: doc/BRIEF.md
# Dual-Organisation Sectored Cache Directory

This block holds the tags and valid flags of a cache that sits on a 32-bit byte-addressed processor bus. Each line covers eight 32-bit words, and each word in a line has its own valid flag next to the valid flag of the line. The `org_sel` input is static. It picks one of two layouts over the same storage. At 0 the directory is direct-mapped with 1024 lines. At 1 it is 2-way set-associative with 512 sets, and one least-recently-used bit per set names the replacement victim. Software flushes the directory before it changes `org_sel`.

Lookups enter on a valid/ready request channel. The answer comes out one cycle later on a valid/ready result channel: hit or miss, the way involved, the word index, whether a new line must be allocated, and an error flag for a duplicated tag. A result that is not taken is held, and no new request is accepted while it waits: `lkp_ready` is high exactly when the result register is empty or is being drained in that cycle. The fill, invalidate and replacement-touch pins are plain single-cycle controls with no handshake. The data array, the bus side and the coherence state are built elsewhere.

Top module: `cdir_sectored_directory`

## Requirements
- R1: In direct-mapped mode, address bits [31:15] form the tag, bits [14:5] pick one of 1024 lines, and bits [4:2] pick the word. `res_word` always returns bits [4:2] of the looked-up address.
- R2: In 2-way mode, bits [13:5] pick one of 512 sets and bits [31:14] form an 18-bit tag. Way 0 and way 1 of a set can hold two different tags at the same time.
- R3: `res_hit` is 1 only when a way holds a valid line whose tag matches and whose flag for the addressed word is set. `res_way` then names that way, with way 0 reported when both ways qualify.
- R4: If the tag matches a valid line but the addressed word's flag is clear, the result is a miss with `res_alloc`=0, and `res_way` names the matching way (the lower one if both match). A fill to that line then sets only that word's flag.
- R5: A fill to a line that is invalid or holds another tag writes the new tag, sets the line valid, and leaves only the filled word's flag set.
- R6: A miss that matches no valid tag gives `res_alloc`=1. `res_way` is then the set's LRU victim in 2-way mode and 0 in direct-mapped mode.
- R7: In 2-way mode, a hitting lookup, a touch and a fill each set their set's LRU bit to the opposite of the way they used. If several of them hit one set in the same cycle, the fill wins over the touch, and the touch wins over the hit. After reset every victim is way 0. Direct-mapped mode leaves the LRU bits alone. A fill in direct-mapped mode always goes to way 0.
- R8: An invalidate clears the line-valid flag of each way whose valid tag matches `inv_addr` and touches no other line. With `inv_all` set, it clears every line.
- R9: A fill in the same cycle as an invalidate is ignored.
- R10: A lookup accepted in the same cycle as a fill, invalidate or touch reports the directory state from before that cycle's updates.
- R11: `res_dual` is 1 when both ways of the set hold a valid line with the looked-up tag.
- R12: A request is accepted when `lkp_valid` and `lkp_ready` are both high, and its result appears on the next cycle. While `res_valid` is high and `res_ready` is low, all result fields stay fixed and `lkp_ready` is low.
- R13: After reset `res_valid` is 0, every line is invalid, and `lkp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| org_sel | input | 1 | 0 direct-mapped, 1 two-way |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup request can be taken |
| lkp_addr | input | 32 | Lookup byte address |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken by consumer |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 1 | Hit way, matching way, or victim way |
| res_word | output | 3 | Word index within line |
| res_alloc | output | 1 | Miss needs a new line |
| res_dual | output | 1 | Both ways hold the tag (error) |
| fill_en | input | 1 | Fill one word |
| fill_addr | input | 32 | Fill byte address |
| fill_way | input | 1 | Way to fill (2-way mode) |
| inv_en | input | 1 | Invalidate request |
| inv_all | input | 1 | Invalidate every line |
| inv_addr | input | 32 | Address to invalidate |
| touch_en | input | 1 | Set LRU from outside |
| touch_addr | input | 32 | Address selecting the set |
| touch_way | input | 1 | Way just used |

## Verification
Two conflicts are provoked on purpose. The first is a lookup in the same cycle as a fill, invalidate or touch. Directed cases look up a line in the cycle that invalidates it, and random traffic mixes all four operations freely. The expected result is always computed from the bench model's state before the cycle's updates, which are applied only afterwards. The second is an invalidate together with a fill. Directed steps and random traffic judge it by later lookups at the filled address, which must still miss.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
  typedef enum logic {
    ORG_DIRECT = 1'b0,
    ORG_TWOWAY = 1'b1
  } org_e;

  localparam int BYTE_OFS_W = 2;
endpackage

// File: rtl/cdir_addr_split.sv
module cdir_addr_split
  import cdir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 1024,
  parameter int WORDS  = 8,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int DIDX_W = $clog2(LINES),
  localparam int SIDX_W = DIDX_W - 1,
  localparam int TAG_W  = ADDR_W - BYTE_OFS_W - WSEL_W - SIDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  org_e              org,
  output logic [TAG_W-1:0]  tag,
  output logic [SIDX_W-1:0] set,
  output logic [DIDX_W-1:0] ent0,
  output logic [DIDX_W-1:0] ent1,
  output logic [WSEL_W-1:0] word
);
  localparam int LO = BYTE_OFS_W + WSEL_W;

  logic unused_byte_bits;
  assign unused_byte_bits = ^addr[BYTE_OFS_W-1:0];

  assign word = addr[LO-1:BYTE_OFS_W];
  assign set  = addr[LO+SIDX_W-1:LO];

  always_comb begin
    if (org == ORG_TWOWAY) begin
      tag  = addr[ADDR_W-1:LO+SIDX_W];
      ent0 = {1'b0, set};
      ent1 = {1'b1, set};
    end else begin
      tag  = {1'b0, addr[ADDR_W-1:LO+DIDX_W]};
      ent0 = addr[LO+DIDX_W-1:LO];
      ent1 = addr[LO+DIDX_W-1:LO];
    end
  end
endmodule

// File: rtl/cdir_tag_store.sv
module cdir_tag_store #(
  parameter int LINES = 1024,
  parameter int WORDS = 8,
  parameter int TAG_W = 18,
  localparam int DIDX_W = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_way,
  input  logic [DIDX_W-1:0] rd_e0,
  input  logic [DIDX_W-1:0] rd_e1,
  output logic [TAG_W-1:0]  rd0_tag,
  output logic              rd0_lv,
  output logic [WORDS-1:0]  rd0_wv,
  output logic [TAG_W-1:0]  rd1_tag,
  output logic              rd1_lv,
  output logic [WORDS-1:0]  rd1_wv,
  input  logic              inv_en,
  input  logic              inv_all,
  input  logic [DIDX_W-1:0] inv_e0,
  input  logic [DIDX_W-1:0] inv_e1,
  input  logic [TAG_W-1:0]  inv_tag,
  input  logic              fill_en,
  input  logic [DIDX_W-1:0] fill_e,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [WSEL_W-1:0] fill_word
);
  logic [LINES-1:0] line_ok;
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [WORDS-1:0] wv_mem  [LINES];

  logic inv_hit0, inv_hit1, fill_present, fill_go;
  logic [WORDS-1:0] fill_onehot;

  assign rd0_tag = tag_mem[rd_e0];
  assign rd0_lv  = line_ok[rd_e0];
  assign rd0_wv  = wv_mem[rd_e0];
  assign rd1_tag = tag_mem[rd_e1];
  assign rd1_lv  = line_ok[rd_e1];
  assign rd1_wv  = wv_mem[rd_e1];

  assign inv_hit0 = line_ok[inv_e0] && (tag_mem[inv_e0] == inv_tag);
  assign inv_hit1 = two_way && line_ok[inv_e1] && (tag_mem[inv_e1] == inv_tag);

  assign fill_go      = fill_en && !inv_en;
  assign fill_present = line_ok[fill_e] && (tag_mem[fill_e] == fill_tag);
  assign fill_onehot  = WORDS'(1) << fill_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_ok <= '0;
    end else if (inv_en) begin
      if (inv_all) begin
        line_ok <= '0;
      end else begin
        if (inv_hit0) line_ok[inv_e0] <= 1'b0;
        if (inv_hit1) line_ok[inv_e1] <= 1'b0;
      end
    end else if (fill_en) begin
      line_ok[fill_e] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      if (fill_present) begin
        wv_mem[fill_e][fill_word] <= 1'b1;
      end else begin
        tag_mem[fill_e] <= fill_tag;
        wv_mem[fill_e]  <= fill_onehot;
      end
    end
  end

  a_r8_flush_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && inv_all |=> line_ok == '0)
    else $error("R8 flush left a valid line");

  a_r5_new_line_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && !fill_present |=> line_ok[$past(fill_e)] && ($countones(wv_mem[$past(fill_e)]) == 1))
    else $error("R5 allocation did not leave exactly one word valid");

  a_r4_word_added: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && fill_present |=> wv_mem[$past(fill_e)][$past(fill_word)])
    else $error("R4 fill to present line did not set word flag");

  a_r9_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && fill_en && !line_ok[fill_e] |=> !line_ok[$past(fill_e)])
    else $error("R9 fill took effect during invalidate");
endmodule

// File: rtl/cdir_lru.sv
module cdir_lru #(
  parameter int SETS = 512,
  localparam int SIDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIDX_W-1:0] rd_set,
  output logic              rd_victim,
  input  logic              hit_we,
  input  logic [SIDX_W-1:0] hit_set,
  input  logic              hit_way,
  input  logic              tch_we,
  input  logic [SIDX_W-1:0] tch_set,
  input  logic              tch_way,
  input  logic              fil_we,
  input  logic [SIDX_W-1:0] fil_set,
  input  logic              fil_way
);
  logic [SETS-1:0] victim_q;

  assign rd_victim = victim_q[rd_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_q <= '0;
    end else begin
      if (hit_we) victim_q[hit_set] <= ~hit_way;
      if (tch_we) victim_q[tch_set] <= ~tch_way;
      if (fil_we) victim_q[fil_set] <= ~fil_way;
    end
  end

  a_r7_fill_points_away: assert property (@(posedge clk) disable iff (!rst_n)
    fil_we |=> victim_q[$past(fil_set)] == ~$past(fil_way))
    else $error("R7 LRU not set away from filled way");

  a_r7_touch_points_away: assert property (@(posedge clk) disable iff (!rst_n)
    tch_we && !(fil_we && fil_set == tch_set) |=> victim_q[$past(tch_set)] == ~$past(tch_way))
    else $error("R7 LRU not set away from touched way");
endmodule

// File: rtl/cdir_sectored_directory.sv
module cdir_sectored_directory
  import cdir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 1024,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              org_sel,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic              res_way,
  output logic [$clog2(WORDS)-1:0] res_word,
  output logic              res_alloc,
  output logic              res_dual,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_way,
  input  logic              inv_en,
  input  logic              inv_all,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              touch_en,
  input  logic [ADDR_W-1:0] touch_addr,
  input  logic              touch_way
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int DIDX_W = $clog2(LINES);
  localparam int SIDX_W = DIDX_W - 1;
  localparam int SETS   = LINES / 2;
  localparam int TAG_W  = ADDR_W - BYTE_OFS_W - WSEL_W - SIDX_W;
  localparam int NSRC   = 4;
  localparam int S_LKP = 0, S_FIL = 1, S_INV = 2, S_TCH = 3;

  org_e org;
  logic two_way;
  assign org     = org_e'(org_sel);
  assign two_way = (org == ORG_TWOWAY);

  logic [ADDR_W-1:0] src_addr [NSRC];
  logic [TAG_W-1:0]  sp_tag   [NSRC];
  logic [SIDX_W-1:0] sp_set   [NSRC];
  logic [DIDX_W-1:0] sp_e0    [NSRC];
  logic [DIDX_W-1:0] sp_e1    [NSRC];
  logic [WSEL_W-1:0] sp_word  [NSRC];

  assign src_addr[S_LKP] = lkp_addr;
  assign src_addr[S_FIL] = fill_addr;
  assign src_addr[S_INV] = inv_addr;
  assign src_addr[S_TCH] = touch_addr;

  for (genvar g = 0; g < NSRC; g++) begin : g_split
    cdir_addr_split #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)) u_split (
      .addr(src_addr[g]), .org(org), .tag(sp_tag[g]), .set(sp_set[g]),
      .ent0(sp_e0[g]), .ent1(sp_e1[g]), .word(sp_word[g]));
  end

  logic [TAG_W-1:0] r0_tag, r1_tag;
  logic             r0_lv, r1_lv;
  logic [WORDS-1:0] r0_wv, r1_wv;
  logic [DIDX_W-1:0] fill_e;
  logic             fill_way_eff;

  assign fill_way_eff = two_way && fill_way;
  assign fill_e       = fill_way_eff ? sp_e1[S_FIL] : sp_e0[S_FIL];

  cdir_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .two_way(two_way),
    .rd_e0(sp_e0[S_LKP]), .rd_e1(sp_e1[S_LKP]),
    .rd0_tag(r0_tag), .rd0_lv(r0_lv), .rd0_wv(r0_wv),
    .rd1_tag(r1_tag), .rd1_lv(r1_lv), .rd1_wv(r1_wv),
    .inv_en(inv_en), .inv_all(inv_all), .inv_e0(sp_e0[S_INV]), .inv_e1(sp_e1[S_INV]),
    .inv_tag(sp_tag[S_INV]),
    .fill_en(fill_en), .fill_e(fill_e), .fill_tag(sp_tag[S_FIL]), .fill_word(sp_word[S_FIL]));

  // Lookup comparison
  logic m0, m1, w0, w1, c_hit, c_way, c_alloc, c_dual, victim, accept;

  assign m0 = r0_lv && (r0_tag == sp_tag[S_LKP]);
  assign m1 = two_way && r1_lv && (r1_tag == sp_tag[S_LKP]);
  assign w0 = m0 && r0_wv[sp_word[S_LKP]];
  assign w1 = m1 && r1_wv[sp_word[S_LKP]];

  always_comb begin
    c_hit   = w0 || w1;
    c_alloc = !m0 && !m1;
    c_dual  = m0 && m1;
    if (c_hit)         c_way = !w0;
    else if (m0 || m1) c_way = !m0;
    else               c_way = two_way && victim;
  end

  assign lkp_ready = !res_valid || res_ready;
  assign accept    = lkp_valid && lkp_ready;

  cdir_lru #(.SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .rd_set(sp_set[S_LKP]), .rd_victim(victim),
    .hit_we(accept && c_hit && two_way), .hit_set(sp_set[S_LKP]), .hit_way(c_way),
    .tch_we(touch_en && two_way), .tch_set(sp_set[S_TCH]), .tch_way(touch_way),
    .fil_we(fill_en && !inv_en && two_way), .fil_set(sp_set[S_FIL]), .fil_way(fill_way));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_way   <= 1'b0;
      res_word  <= '0;
      res_alloc <= 1'b0;
      res_dual  <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_hit   <= c_hit;
      res_way   <= c_way;
      res_word  <= sp_word[S_LKP];
      res_alloc <= c_alloc;
      res_dual  <= c_dual;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_way)
      && $stable(res_word) && $stable(res_alloc) && $stable(res_dual))
    else $error("R12 result changed while stalled");

  a_r12_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid && lkp_ready |=> res_valid)
    else $error("R12 accepted request produced no result");

  a_r6_alloc_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_alloc |-> !res_hit && !res_dual)
    else $error("R6 allocation flagged on a hit");

  a_r11_dual_needs_twoway: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_dual |-> org_sel && !res_alloc)
    else $error("R11 dual match outside two-way mode");
endmodule

// File: tb/cdir_sectored_directory_tb.sv
module cdir_sectored_directory_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, org_sel = 1'b1;
  logic lkp_valid = 1'b0, lkp_ready, res_valid, res_ready = 1'b1;
  logic [31:0] lkp_addr = '0, fill_addr = '0, inv_addr = '0, touch_addr = '0;
  logic res_hit, res_way, res_alloc, res_dual;
  logic [2:0] res_word;
  logic fill_en = 1'b0, fill_way = 1'b0, inv_en = 1'b0, inv_all = 1'b0;
  logic touch_en = 1'b0, touch_way = 1'b0;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdir_sectored_directory u_dut (
    .clk(clk), .rst_n(rst_n), .org_sel(org_sel),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_addr(lkp_addr),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_way(res_way),
    .res_word(res_word), .res_alloc(res_alloc), .res_dual(res_dual),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_way(fill_way),
    .inv_en(inv_en), .inv_all(inv_all), .inv_addr(inv_addr),
    .touch_en(touch_en), .touch_addr(touch_addr), .touch_way(touch_way));

  // Reference model
  logic [17:0] m_tag [1024];
  logic        m_lv  [1024];
  logic [7:0]  m_wv  [1024];
  logic        m_lru [512];

  function automatic logic [17:0] f_tag(logic [31:0] a);
    return org_sel ? a[31:14] : {1'b0, a[31:15]};
  endfunction

  function automatic int f_e(logic [31:0] a, logic way);
    return org_sel ? (int'(way) * 512 + int'(a[13:5])) : int'(a[14:5]);
  endfunction

  // {hit, way, word[2:0], alloc, dual}
  function automatic logic [6:0] f_look(logic [31:0] a);
    int e0 = f_e(a, 1'b0), e1 = f_e(a, 1'b1);
    logic [17:0] t = f_tag(a);
    logic m0 = m_lv[e0] && m_tag[e0] == t;
    logic m1 = org_sel && m_lv[e1] && m_tag[e1] == t;
    logic w0 = m0 && m_wv[e0][a[4:2]];
    logic w1 = m1 && m_wv[e1][a[4:2]];
    logic hit = w0 || w1;
    logic way = hit ? !w0 : ((m0 || m1) ? !m0 : (org_sel && m_lru[a[13:5]]));
    return {hit, way, a[4:2], !m0 && !m1, m0 && m1};
  endfunction

  task automatic model_step(logic lk, logic [31:0] la, logic fe, logic [31:0] fa, logic fw,
                            logic ie, logic [31:0] ia, logic iall,
                            logic te, logic [31:0] ta, logic tw);
    logic [6:0] r = f_look(la);
    int ie0 = f_e(ia, 1'b0), ie1 = f_e(ia, 1'b1), fe_i = f_e(fa, fw);
    logic im0 = m_lv[ie0] && m_tag[ie0] == f_tag(ia);
    logic im1 = org_sel && m_lv[ie1] && m_tag[ie1] == f_tag(ia);
    logic fpres = m_lv[fe_i] && m_tag[fe_i] == f_tag(fa);
    if (org_sel) begin
      if (lk && r[6]) m_lru[la[13:5]] = !r[5];
      if (te) m_lru[ta[13:5]] = !tw;
      if (fe && !ie) m_lru[fa[13:5]] = !fw;
    end
    if (ie) begin
      if (iall) begin
        for (int k = 0; k < 1024; k++) m_lv[k] = 1'b0;
      end else begin
        if (im0) m_lv[ie0] = 1'b0;
        if (im1) m_lv[ie1] = 1'b0;
      end
    end else if (fe) begin
      if (fpres) m_wv[fe_i][fa[4:2]] = 1'b1;
      else begin
        m_tag[fe_i] = f_tag(fa);
        m_wv[fe_i] = 8'(1) << fa[4:2];
        m_lv[fe_i] = 1'b1;
      end
    end
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus starting and ending at a falling edge.
  task automatic cyc(string req, logic lk, logic [31:0] la, logic fe, logic [31:0] fa, logic fw,
                     logic ie, logic [31:0] ia, logic iall,
                     logic te, logic [31:0] ta, logic tw);
    logic [6:0] exp = f_look(la);
    lkp_valid = lk; lkp_addr = la; fill_en = fe; fill_addr = fa; fill_way = fw;
    inv_en = ie; inv_addr = ia; inv_all = iall; touch_en = te; touch_addr = ta; touch_way = tw;
    @(posedge clk);
    model_step(lk, la, fe, fa, fw, ie, ia, iall, te, ta, tw);
    @(negedge clk);
    lkp_valid = 1'b0; fill_en = 1'b0; inv_en = 1'b0; inv_all = 1'b0; touch_en = 1'b0;
    if (lk) begin
      check(req, "res_valid", 32'(res_valid), 32'd1);
      check(req, "{hit,way,word,alloc,dual}",
            32'({res_hit, res_way, res_word, res_alloc, res_dual}), 32'(exp));
    end
  endtask

  task automatic look(string req, logic [31:0] a);
    cyc(req, 1'b1, a, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask
  task automatic fill(logic [31:0] a, logic w);
    cyc("R5", 1'b0, '0, 1'b1, a, w, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  function automatic logic [31:0] sa(logic [17:0] t, logic [8:0] s, logic [2:0] w);
    return {t, s, w, 2'b00};
  endfunction
  function automatic logic [31:0] dm(logic [16:0] t, logic [9:0] i, logic [2:0] w);
    return {t, i, w, 2'b00};
  endfunction

  function automatic logic [31:0] rnd_addr();
    logic [17:0] t; logic [9:0] ix;
    case ($urandom % 4)
      0: t = 18'h00001; 1: t = 18'h2AAAA; 2: t = 18'h3FFFF; default: t = 18'h12345;
    endcase
    case ($urandom % 4)
      0: ix = 10'd0; 1: ix = 10'd1; 2: ix = 10'd1023; default: ix = 10'd512;
    endcase
    if (org_sel) return sa(t, ix[8:0], 3'($urandom));
    return dm(t[16:0], ix, 3'($urandom));
  endfunction

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++) begin
      logic ie = ($urandom % 20) == 0;
      cyc("R10", ($urandom % 10) < 7, rnd_addr(), ($urandom % 10) < 3, rnd_addr(), 1'($urandom),
          ie, rnd_addr(), ie && (($urandom % 40) == 0),
          ($urandom % 10) == 0, rnd_addr(), 1'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] exp1, exp2;
    void'($urandom(32'h1d2c3b4a));
    for (int k = 0; k < 1024; k++) begin m_lv[k] = 1'b0; m_tag[k] = '0; m_wv[k] = '0; end
    for (int k = 0; k < 512; k++) m_lru[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R13", "res_valid after reset", 32'(res_valid), 32'd0);
    check("R13", "lkp_ready after reset", 32'(lkp_ready), 32'd1);

    // R12 back-pressure
    res_ready = 1'b0;
    lkp_valid = 1'b1; lkp_addr = sa(18'h11, 9'd5, 3'd3);
    exp1 = f_look(lkp_addr);
    @(negedge clk);
    lkp_addr = sa(18'h22, 9'd6, 3'd6);
    exp2 = f_look(lkp_addr);
    for (int k = 0; k < 3; k++) begin
      check("R12", "held valid", 32'(res_valid), 32'd1);
      check("R12", "ready low while held", 32'(lkp_ready), 32'd0);
      check("R12", "held fields", 32'({res_hit, res_way, res_word, res_alloc, res_dual}), 32'(exp1));
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    lkp_valid = 1'b0;
    check("R12", "second result", 32'({res_hit, res_way, res_word, res_alloc, res_dual}), 32'(exp2));
    @(negedge clk);
    check("R12", "drained", 32'(res_valid), 32'd0);

    // Directed, two-way mode
    look("R6", sa(18'h11, 9'd5, 3'd2));
    fill(sa(18'h11, 9'd5, 3'd2), 1'b0);
    look("R3", sa(18'h11, 9'd5, 3'd2));
    look("R4", sa(18'h11, 9'd5, 3'd3));
    fill(sa(18'h11, 9'd5, 3'd3), 1'b0);
    look("R4", sa(18'h11, 9'd5, 3'd3));
    look("R7", sa(18'h22, 9'd5, 3'd0));
    fill(sa(18'h22, 9'd5, 3'd0), 1'b1);
    look("R2", sa(18'h22, 9'd5, 3'd0));
    look("R2", sa(18'h11, 9'd5, 3'd2));
    fill(sa(18'h33, 9'd5, 3'd1), 1'b0);
    look("R5", sa(18'h11, 9'd5, 3'd2));
    look("R5", sa(18'h33, 9'd5, 3'd2));
    cyc("R10", 1'b1, sa(18'h33, 9'd5, 3'd1), 1'b0, '0, 1'b0, 1'b1, sa(18'h33, 9'd5, 3'd0), 1'b0,
        1'b0, '0, 1'b0);
    look("R8", sa(18'h33, 9'd5, 3'd1));
    look("R8", sa(18'h22, 9'd5, 3'd0));
    cyc("R9", 1'b0, '0, 1'b1, sa(18'h44, 9'd8, 3'd4), 1'b0, 1'b1, sa(18'h55, 9'd8, 3'd0), 1'b0,
        1'b0, '0, 1'b0);
    look("R9", sa(18'h44, 9'd8, 3'd4));
    fill(sa(18'h66, 9'd7, 3'd0), 1'b0);
    fill(sa(18'h66, 9'd7, 3'd0), 1'b1);
    look("R11", sa(18'h66, 9'd7, 3'd0));
    cyc("R7", 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, sa(18'h0, 9'd9, 3'd0), 1'b1);
    look("R7", sa(18'h77, 9'd9, 3'd0));
    cyc("R7", 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, sa(18'h0, 9'd9, 3'd0), 1'b0);
    look("R7", sa(18'h77, 9'd9, 3'd0));
    cyc("R8", 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, '0, 1'b1, 1'b0, '0, 1'b0);
    look("R8", sa(18'h22, 9'd5, 3'd0));
    random_phase(1500);

    // Direct-mapped mode after flush
    cyc("R8", 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, '0, 1'b1, 1'b0, '0, 1'b0);
    org_sel = 1'b0;
    fill(dm(17'h1, 10'd700, 3'd5), 1'b1);
    look("R1", dm(17'h1, 10'd700, 3'd5));
    look("R1", dm(17'h2, 10'd700, 3'd5));
    fill(dm(17'h2, 10'd700, 3'd5), 1'b0);
    look("R1", dm(17'h1, 10'd700, 3'd5));
    random_phase(1500);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule